// File: doc/BRIEF.md
# Quadrature Counter Channel with Byte-Port

One channel of an incremental-encoder counter. It decodes two count inputs and an index input, either as pulse/direction or as quadrature at x1, x2 or x4 resolution. It keeps a 24-bit up/down count under one of four count modes, and raises a one-cycle event pulse from a selectable source. A host reaches everything through an 8-bit bus with two addresses. The data address moves three-byte values through a shared, auto-advancing byte pointer. The control address takes command bytes on write and returns a flag byte on read.

The count is never written directly. The host fills the preset register and then commands a preset-to-count copy. To read the count, the host commands a count-to-latch copy and then reads the latch. The inputs are synchronized and sampled at a rate set by a filter prescaler, which is loaded from the preset's low byte.

Top module: `qcnt_channel`

## Requirements
- R1: A control-address write selects a target from bits 7:5: 000 reset/load, 001 count mode, 010 I/O control, 011 index control. In count mode, bits 2:1 give the count mode (0 normal, 1 range limit, 2 non-recycle, 3 modulo-N) and bits 4:3 give decoding (00 pulse/direction, 01 x1, 10 x2, 11 x4).
- R2: Data-address writes fill the preset low byte first, and data-address reads return the latch low byte first. Each data access advances the shared byte pointer, which wraps after the third byte. A reset/load command with bit 0 set returns the pointer to the low byte.
- R3: In a reset/load command, bits 2:1 = 01 zero the count, 10 clear the borrow and carry toggles, and 11 clear the error flag.
- R4: In a reset/load command, bits 4:3 = 01 copy preset to count, 10 copy count to latch, and 11 copy the preset low byte into the prescaler. Loading the prescaler restarts its divider, and the inputs are then sampled once every prescaler+1 clocks.
- R5: A control-address read returns the flag byte: bit 0 borrow toggle, bit 1 carry toggle, bit 4 error, bit 5 direction (1 = up), all other bits 0. All flags are 0 after reset.
- R6: In pulse/direction decoding, each rising edge of A counts once: up when B is 1, down when B is 0.
- R7: The up sequence of quadrature input pairs {A,B} is 00,10,11,01. x1 counts once per full cycle, on the rise of A going up and on the fall of A going down. x2 counts on both edges of A. x4 counts on every edge.
- R8: In normal mode the count wraps from 0xFFFFFF to 0 going up, which toggles the carry flag. It wraps from 0 to 0xFFFFFF going down, which toggles the borrow flag.
- R9: In range-limit mode the count stays within 0 and the preset. It holds at either end and does not toggle the flags.
- R10: In non-recycle mode the count wraps once as in normal mode, toggling its flag, and then freezes until a preset load or a count clear.
- R11: In modulo-N mode the count goes from the preset to 0 going up and from 0 to the preset going down, toggling carry or borrow.
- R12: With I/O control bit 0 clear, encoder activity leaves the count unchanged.
- R13: Index control bit 1 selects the active index edge (1 rising, 0 falling). On an active edge the preset is loaded into the count when I/O control bit 1 is 0. When index control bit 0 is set and decoding is quadrature, the edge acts only while A and B are both low.
- R14: I/O control bits 4:3 select the event source: 0 carry, 1 compare (count steps onto the preset), 2 carry or borrow, 3 index edge. In quadrature decoding, A and B changing in the same sample sets a sticky error flag and does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_ctl_i | input | 1 | Address select: 1 control, 0 data |
| bus_wr_i | input | 1 | Write strobe, one cycle per byte |
| bus_rd_i | input | 1 | Read strobe, one cycle per byte |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while addressed |
| enc_a_i | input | 1 | Encoder A / pulse input |
| enc_b_i | input | 1 | Encoder B / direction input |
| enc_idx_i | input | 1 | Index input |
| event_o | output | 1 | One-cycle event pulse |

## Verification
The bounded-range and freeze properties assume that the preset and the count mode change only through bus writes. They also assume that no bus write lands in the cycle they judge, so their antecedents exclude any cycle with a write strobe. The stimulus holds every encoder level for six clocks, which is longer than the synchronizer plus one sample at the default prescaler. Each transition is therefore seen as a single step, except for the deliberate two-input change that tests the error flag. Reads and writes are one-cycle strobes that never overlap.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  typedef enum logic [2:0] {TGT_RLD = 3'b000, TGT_CMR = 3'b001,
                            TGT_IOR = 3'b010, TGT_IDR = 3'b011} tgt_e;
  typedef enum logic [1:0] {CM_NORMAL, CM_RANGE, CM_NOREC, CM_MODN} cmode_e;
  typedef enum logic [1:0] {DEC_PD, DEC_X1, DEC_X2, DEC_X4} dec_e;
  typedef enum logic [1:0] {EV_CARRY, EV_CMP, EV_CB, EV_IDX} evsel_e;
endpackage

// File: rtl/qcnt_sampler.sv
module qcnt_sampler #(
  parameter int N     = 3,
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     raw_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             restart_i,
  output logic             strobe_o,
  output logic [N-1:0]     cur_o,
  output logic [N-1:0]     old_o
);
  logic [N-1:0] s1_q, s2_q, old_q;
  logic [PSC_W-1:0] div_q;

  assign strobe_o = (div_q == psc_i);
  assign cur_o    = s2_q;
  assign old_o    = old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      old_q <= '0;
      div_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (restart_i || strobe_o) div_q <= '0;
      else                       div_q <= div_q + 1'b1;
      if (strobe_o) old_q <= s2_q;
    end
  end
endmodule

// File: rtl/qcnt_decoder.sv
module qcnt_decoder
  import qcnt_pkg::*;
(
  input  logic strobe_i,
  input  dec_e dec_i,
  input  logic a_i,
  input  logic b_i,
  input  logic pa_i,
  input  logic pb_i,
  output logic up_o,
  output logic dn_o,
  output logic err_o
);
  logic ac, bc, fwd;

  always_comb begin
    ac    = a_i ^ pa_i;
    bc    = b_i ^ pb_i;
    up_o  = 1'b0;
    dn_o  = 1'b0;
    fwd   = 1'b0;
    err_o = strobe_i && (dec_i != DEC_PD) && ac && bc;
    if (strobe_i) begin
      unique case (dec_i)
        DEC_PD: if (ac && a_i) begin up_o = b_i; dn_o = !b_i; end
        DEC_X1: if (ac && !b_i && !bc) begin up_o = a_i; dn_o = !a_i; end
        DEC_X2: if (ac && !bc) begin up_o = a_i ^ b_i; dn_o = !(a_i ^ b_i); end
        DEC_X4: if (ac ^ bc) begin
          fwd  = ac ? (a_i ^ b_i) : !(a_i ^ b_i);
          up_o = fwd;
          dn_o = !fwd;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qcnt_core.sv
module qcnt_core
  import qcnt_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         up_i,
  input  logic         dn_i,
  input  cmode_e       mode_i,
  input  logic [W-1:0] preset_i,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic         clr_flags_i,
  output logic [W-1:0] cnt_o,
  output logic         bt_o,
  output logic         ct_o,
  output logic         dir_o,
  output logic         halt_o,
  output logic         carry_p_o,
  output logic         borrow_p_o,
  output logic         cmp_p_o
);
  logic [W-1:0] cnt_q, lim, nxt;
  logic halt_q, go_up, go_dn, wrap, carry, borrow;

  always_comb begin
    lim    = (mode_i == CM_RANGE || mode_i == CM_MODN) ? preset_i : '1;
    go_up  = en_i && up_i && !halt_q;
    go_dn  = en_i && dn_i && !halt_q;
    nxt    = cnt_q;
    wrap   = 1'b0;
    carry  = 1'b0;
    borrow = 1'b0;
    if (go_up) begin
      if (cnt_q >= lim) begin
        carry = 1'b1;
        if (mode_i != CM_RANGE) begin nxt = '0; wrap = 1'b1; end
      end else nxt = cnt_q + 1'b1;
    end else if (go_dn) begin
      if (cnt_q == '0) begin
        borrow = 1'b1;
        if (mode_i != CM_RANGE) begin nxt = lim; wrap = 1'b1; end
      end else nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      halt_q     <= 1'b0;
      bt_o       <= 1'b0;
      ct_o       <= 1'b0;
      dir_o      <= 1'b0;
      carry_p_o  <= 1'b0;
      borrow_p_o <= 1'b0;
      cmp_p_o    <= 1'b0;
    end else begin
      if (clr_i) begin
        cnt_q  <= '0;
        halt_q <= 1'b0;
      end else if (ld_i) begin
        cnt_q  <= preset_i;
        halt_q <= 1'b0;
      end else begin
        cnt_q <= nxt;
        if (wrap && mode_i == CM_NOREC) halt_q <= 1'b1;
      end
      if (clr_flags_i) begin
        bt_o <= 1'b0;
        ct_o <= 1'b0;
      end else begin
        if (go_dn && wrap) bt_o <= !bt_o;
        if (go_up && wrap) ct_o <= !ct_o;
      end
      if (en_i && up_i)      dir_o <= 1'b1;
      else if (en_i && dn_i) dir_o <= 1'b0;
      carry_p_o  <= carry;
      borrow_p_o <= borrow;
      cmp_p_o    <= (go_up || go_dn) && (nxt == preset_i) && (nxt != cnt_q);
    end
  end

  assign cnt_o  = cnt_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/qcnt_channel.sv
module qcnt_channel
  import qcnt_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PSC_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_ctl_i,
  input  logic       bus_wr_i,
  input  logic       bus_rd_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       enc_a_i,
  input  logic       enc_b_i,
  input  logic       enc_idx_i,
  output logic       event_o
);
  localparam int NB = CNT_W / 8;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;

  logic [PW-1:0]    ptr_q, ptr_nxt;
  logic [CNT_W-1:0] preset_q, latch_q, cnt;
  logic [PSC_W-1:0] psc_q;
  cmode_e cmode_q;
  dec_e   dec_q;
  evsel_e evsel_q;
  logic   ab_en_q, idx_ld_n_q, sync_q, pol_q, err_q, idx_p_q;
  tgt_e   tgt;
  logic   cmd_rld, clr_cnt, clr_flags, clr_err, ld_cnt, ld_lat, ld_psc;
  logic   data_wr, data_rd, strobe, step_up, step_dn, dec_err;
  logic   idx_edge, sync_ok, idx_act, idx_ld, bt, ct, dir, halt;
  logic   carry_p, borrow_p, cmp_p;
  logic [2:0] cur, old;

  assign tgt       = tgt_e'(bus_wdata_i[7:5]);
  assign cmd_rld   = bus_wr_i && bus_ctl_i && (tgt == TGT_RLD);
  assign clr_cnt   = cmd_rld && (bus_wdata_i[2:1] == 2'b01);
  assign clr_flags = cmd_rld && (bus_wdata_i[2:1] == 2'b10);
  assign clr_err   = cmd_rld && (bus_wdata_i[2:1] == 2'b11);
  assign ld_cnt    = cmd_rld && (bus_wdata_i[4:3] == 2'b01);
  assign ld_lat    = cmd_rld && (bus_wdata_i[4:3] == 2'b10);
  assign ld_psc    = cmd_rld && (bus_wdata_i[4:3] == 2'b11);
  assign data_wr   = bus_wr_i && !bus_ctl_i;
  assign data_rd   = bus_rd_i && !bus_ctl_i && !bus_wr_i;
  assign ptr_nxt   = (ptr_q == PW'(NB - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      latch_q    <= '0;
      psc_q      <= '0;
      cmode_q    <= CM_NORMAL;
      dec_q      <= DEC_PD;
      evsel_q    <= EV_CARRY;
      ab_en_q    <= 1'b0;
      idx_ld_n_q <= 1'b1;
      sync_q     <= 1'b0;
      pol_q      <= 1'b0;
      err_q      <= 1'b0;
      idx_p_q    <= 1'b0;
    end else begin
      if (cmd_rld && bus_wdata_i[0]) ptr_q <= '0;
      else if (data_wr || data_rd)   ptr_q <= ptr_nxt;
      if (ld_lat) latch_q <= cnt;
      if (ld_psc) psc_q <= preset_q[PSC_W-1:0];
      if (bus_wr_i && bus_ctl_i) begin
        unique case (tgt)
          TGT_CMR: begin
            cmode_q <= cmode_e'(bus_wdata_i[2:1]);
            dec_q   <= dec_e'(bus_wdata_i[4:3]);
          end
          TGT_IOR: begin
            ab_en_q    <= bus_wdata_i[0];
            idx_ld_n_q <= bus_wdata_i[1];
            evsel_q    <= evsel_e'(bus_wdata_i[4:3]);
          end
          TGT_IDR: begin
            sync_q <= bus_wdata_i[0];
            pol_q  <= bus_wdata_i[1];
          end
          default: ;
        endcase
      end
      if (clr_err)      err_q <= 1'b0;
      else if (dec_err) err_q <= 1'b1;
      idx_p_q <= idx_act;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_preset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              preset_q[g*8 +: 8] <= '0;
      else if (data_wr && ptr_q == PW'(g))      preset_q[g*8 +: 8] <= bus_wdata_i;
    end
  end

  qcnt_sampler #(.N(3), .PSC_W(PSC_W)) u_smp (
    .clk_i, .rst_ni,
    .raw_i({enc_idx_i, enc_b_i, enc_a_i}),
    .psc_i(psc_q), .restart_i(ld_psc),
    .strobe_o(strobe), .cur_o(cur), .old_o(old)
  );

  qcnt_decoder u_dec (
    .strobe_i(strobe), .dec_i(dec_q),
    .a_i(cur[0]), .b_i(cur[1]), .pa_i(old[0]), .pb_i(old[1]),
    .up_o(step_up), .dn_o(step_dn), .err_o(dec_err)
  );

  // index edge, optionally qualified by both count inputs low
  assign idx_edge = strobe && (pol_q ? (cur[2] && !old[2]) : (!cur[2] && old[2]));
  assign sync_ok  = !sync_q || (dec_q == DEC_PD) || (!cur[0] && !cur[1]);
  assign idx_act  = idx_edge && sync_ok;
  assign idx_ld   = idx_act && !idx_ld_n_q;

  qcnt_core #(.W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .en_i(ab_en_q), .up_i(step_up), .dn_i(step_dn),
    .mode_i(cmode_q), .preset_i(preset_q),
    .clr_i(clr_cnt), .ld_i(ld_cnt || idx_ld), .clr_flags_i(clr_flags),
    .cnt_o(cnt), .bt_o(bt), .ct_o(ct), .dir_o(dir), .halt_o(halt),
    .carry_p_o(carry_p), .borrow_p_o(borrow_p), .cmp_p_o(cmp_p)
  );

  always_comb begin
    unique case (evsel_q)
      EV_CARRY: event_o = carry_p;
      EV_CMP:   event_o = cmp_p;
      EV_CB:    event_o = carry_p || borrow_p;
      default:  event_o = idx_p_q;
    endcase
  end

  assign bus_rdata_o = bus_ctl_i ? {2'b00, dir, err_q, 2'b00, ct, bt}
                                 : latch_q[ptr_q*8 +: 8];
endmodule

// File: rtl/qcnt_channel_sva.sv
module qcnt_channel_sva
  import qcnt_pkg::*;
#(
  parameter int W  = 24,
  parameter int NB = 3,
  parameter int PW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_wr_i,
  input logic [PW-1:0] ptr,
  input logic [1:0]    mode,
  input logic [W-1:0]  cnt,
  input logic [W-1:0]  preset,
  input logic          err,
  input logic          halt,
  input logic          up,
  input logic          dn,
  input logic          idx_ld
);
  p_ptr_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr < PW'(NB));

  p_step_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up && dn));

  p_range_clamp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CM_RANGE && cnt <= preset && !bus_wr_i) |=> (cnt <= preset));

  p_halt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !bus_wr_i && !idx_ld) |=> $stable(cnt));

  p_modn_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CM_MODN && cnt <= preset && !bus_wr_i) |=> (cnt <= preset));

  p_err_sticky_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && !bus_wr_i) |=> err);
endmodule

bind qcnt_channel qcnt_channel_sva #(.W(CNT_W), .NB(NB), .PW(PW)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .ptr(ptr_q),
  .mode(cmode_q), .cnt(cnt), .preset(preset_q), .err(err_q), .halt(halt),
  .up(step_up), .dn(step_dn), .idx_ld(idx_ld)
);

// File: tb/qcnt_channel_bench.sv
module qcnt_channel_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_ctl = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic event_w;
  int n_chk = 0, n_fail = 0, ev_cnt = 0;
  bit done = 1'b0;
  logic [1:0] ph = 2'd0;

  always #2.5 clk = ~clk;

  qcnt_channel u_qcnt_channel (
    .clk_i(clk), .rst_ni(rst_n), .bus_ctl_i(bus_ctl), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .enc_a_i(enc_a), .enc_b_i(enc_b), .enc_idx_i(enc_idx), .event_o(event_w)
  );

  always @(posedge clk) if (rst_n && event_w) ev_cnt++;

  // {cmr, preset, up, phases, expected count, expected flags & 0x33}
  localparam logic [72:0] VEC [0:9] = '{
    {8'h38, 24'd100, 1'b1, 8'd8, 24'd108,     8'h20},
    {8'h38, 24'd100, 1'b0, 8'd8, 24'd92,      8'h00},
    {8'h30, 24'd10,  1'b1, 8'd8, 24'd14,      8'h20},
    {8'h28, 24'd10,  1'b1, 8'd8, 24'd12,      8'h20},
    {8'h28, 24'd10,  1'b0, 8'd8, 24'd8,       8'h00},
    {8'h3E, 24'd5,   1'b1, 8'd3, 24'd2,       8'h22},
    {8'h3A, 24'd5,   1'b1, 8'd3, 24'd5,       8'h20},
    {8'h3A, 24'd5,   1'b0, 8'd7, 24'd0,       8'h00},
    {8'h38, 24'd1,   1'b0, 8'd3, 24'hFFFFFE,  8'h01},
    {8'h3C, 24'd1,   1'b0, 8'd3, 24'hFFFFFF,  8'h01}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1, 8: return "R8";
      2, 3, 4: return "R7";
      5:       return "R11";
      6, 7:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ctl, input logic [7:0] d);
    @(negedge clk);
    bus_ctl = ctl; wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic ctl, output logic [7:0] d);
    @(negedge clk);
    bus_ctl = ctl; bus_rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wp(input logic [23:0] v);
    wr(1'b1, 8'h01);
    wr(1'b0, v[7:0]);
    wr(1'b0, v[15:8]);
    wr(1'b0, v[23:16]);
  endtask

  task automatic rdc(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    wr(1'b1, 8'h11);
    rd(1'b0, b0);
    rd(1'b0, b1);
    rd(1'b0, b2);
    v = {b2, b1, b0};
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic mv(input logic up, input int n);
    for (int k = 0; k < n; k++) begin
      ph = up ? ph + 2'd1 : ph - 2'd1;
      enc_a = ph[0] ^ ph[1];
      enc_b = ph[1];
      settle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] c0, c1;
    logic [7:0] f, b;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // reset state
    rd(1'b1, f);   chk("R5 reset flags", 32'(f), 32'h00);
    rdc(c0);       chk("R1 reset count", 32'(c0), 32'h0);

    wr(1'b1, 8'h43);  // A/B on, index load off, carry event

    for (int i = 0; i < 10; i++) begin
      wr(1'b1, VEC[i][72:65]);
      wp(VEC[i][64:41]);
      wr(1'b1, 8'h08);
      wr(1'b1, 8'h04);
      mv(VEC[i][40], int'(VEC[i][39:32]));
      rdc(c0);
      chk(vtag(i), 32'(c0), 32'(VEC[i][31:8]));
      rd(1'b1, f);
      chk(vtag(i), 32'(f & 8'h33), 32'(VEC[i][7:0]));
    end

    // R2: pointer wraps to low byte on fourth read; bit 0 resets pointer
    wp(24'hA1B2C3);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h11);
    rd(1'b0, b); rd(1'b0, b); rd(1'b0, b); rd(1'b0, b);
    chk("R2 pointer wrap", 32'(b), 32'hC3);
    rd(1'b0, b);
    wr(1'b1, 8'h01);
    rd(1'b0, b);
    chk("R2 pointer reset", 32'(b), 32'hC3);

    // R3: count clear
    wr(1'b1, 8'h02);
    rdc(c0); chk("R3 count clear", 32'(c0), 32'h0);

    // R12: inputs disabled
    wr(1'b1, 8'h38);
    wr(1'b1, 8'h42);
    mv(1'b1, 4);
    rdc(c1); chk("R12 disabled inputs", 32'(c1), 32'h0);
    wr(1'b1, 8'h43);

    // R14: carry event on wrap in normal mode
    wp(24'hFFFFFF);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h04);
    e0 = ev_cnt;
    mv(1'b1, 1);
    rdc(c0); chk("R8 carry wrap", 32'(c0), 32'h0);
    chk("R14 carry event", 32'(ev_cnt - e0), 32'd1);
    rd(1'b1, f); chk("R8 carry toggle", 32'(f & 8'h03), 32'h02);

    // R14: illegal transition sets sticky error
    rdc(c0);
    ph = ph + 2'd2;
    enc_a = ph[0] ^ ph[1];
    enc_b = ph[1];
    settle();
    rd(1'b1, f);  chk("R14 error flag", 32'(f & 8'h10), 32'h10);
    rdc(c1);      chk("R14 no count on error", 32'(c1), 32'(c0));
    wr(1'b1, 8'h06);
    rd(1'b1, f);  chk("R3 error clear", 32'(f & 8'h10), 32'h00);

    // R13: index load, positive polarity, index event
    wr(1'b1, 8'h59);
    wr(1'b1, 8'h62);
    wp(24'h123456);
    e0 = ev_cnt;
    enc_idx = 1'b1; settle();
    rdc(c0); chk("R13 index load", 32'(c0), 32'h123456);
    chk("R14 index event", 32'(ev_cnt - e0), 32'd1);
    enc_idx = 1'b0; settle();
    wr(1'b1, 8'h5B);
    wr(1'b1, 8'h02);
    enc_idx = 1'b1; settle();
    rdc(c0); chk("R13 index load disabled", 32'(c0), 32'h0);
    enc_idx = 1'b0; settle();

    // R13: synchronous qualification
    wr(1'b1, 8'h59);
    wr(1'b1, 8'h63);
    while (ph != 2'd1) mv(1'b1, 1);
    wr(1'b1, 8'h02);
    enc_idx = 1'b1; settle();
    rdc(c0); chk("R13 sync blocked", 32'(c0), 32'h0);
    enc_idx = 1'b0; settle();
    mv(1'b0, 1);
    enc_idx = 1'b1; settle();
    rdc(c0); chk("R13 sync allowed", 32'(c0), 32'h123456);
    enc_idx = 1'b0; settle();
    wr(1'b1, 8'h60);
    wr(1'b1, 8'h43);

    // R4: prescaler load slows sampling
    wp(24'h000014);
    wr(1'b1, 8'h19);
    wr(1'b1, 8'h02);
    mv(1'b1, 1);
    rdc(c0); chk("R4 prescaler wait", 32'(c0), 32'h0);
    repeat (40) @(negedge clk);
    rdc(c0); chk("R4 prescaler sample", 32'(c0), 32'h1);
    wp(24'h000000);
    wr(1'b1, 8'h19);

    // R6: pulse/direction
    wr(1'b1, 8'h20);
    enc_a = 1'b0; enc_b = 1'b1; settle();
    wr(1'b1, 8'h02);
    for (int k = 0; k < 3; k++) begin
      enc_a = 1'b1; settle();
      enc_a = 1'b0; settle();
    end
    rdc(c0); chk("R6 pulse up", 32'(c0), 32'd3);
    enc_b = 1'b0; settle();
    for (int k = 0; k < 2; k++) begin
      enc_a = 1'b1; settle();
      enc_a = 1'b0; settle();
    end
    rdc(c0); chk("R6 pulse down", 32'(c0), 32'd1);
    rd(1'b1, f); chk("R5 direction down", 32'(f & 8'h20), 32'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule